// File: doc/BRIEF.md
# Widening Signed Shift-Left Unit

This block takes a 128-bit vector operand and one 64-bit half of it. It treats that half as a set of signed lanes of 8, 16 or 32 bits. Each lane is sign-extended to double width, shifted left and truncated to the doubled width. The results are packed into a 128-bit output. A 7-bit immediate sets both the lane size and the shift amount. Its 4-bit high field `imm_hi` and its 3-bit low field `imm_lo` are decoded together.

The lane size comes from the highest set bit of `imm_hi[2:0]`. The shift is the value of `{imm_hi, imm_lo}` minus the lane size. Two encodings are not computed. When `imm_hi[3]` is set, the encoding is undefined. When `imm_hi` is zero, the encoding belongs to another operation class. Each of these cases raises its own flag. A third flag marks the zero-shift case, where the operation reduces to plain sign extension.

The unit is registered. Inputs are taken on a clock edge where `in_valid` is high, and the outcome appears one clock later.

Top module: `wsl_unit`

## Requirements
- R1: `hi_half`=0 takes the lanes from `src[63:0]`; `hi_half`=1 takes them from `src[127:64]`.
- R2: The lane size is decoded from `imm_hi`: `0001` gives 8-bit lanes, `001x` gives 16-bit lanes, `01xx` gives 32-bit lanes. This yields 8, 4 or 2 lanes.
- R3: The shift amount is `{imm_hi,imm_lo}` read as unsigned, minus the lane size. It ranges from 0 to lane size minus 1.
- R4: Each lane is read as signed, sign-extended, shifted left, and truncated to twice the lane size.
- R5: Output lane e occupies `result[2W*(e+1)-1 : 2W*e]`, where W is the lane size. Lane 0 is at the least significant end.
- R6: When `imm_hi[3]`=1, `out_undef` is raised one clock after the accepted input.
- R7: When `imm_hi`=`0000`, `out_redirect` is raised one clock after the accepted input, and `out_undef` stays low.
- R8: While either error flag is high, `result` is all zeros and `out_valid` is low. At most one of `out_valid`, `out_undef` and `out_redirect` is high at a time.
- R9: `out_pure_ext` is high with `out_valid` exactly when `imm_lo`=`000` and a single bit of `imm_hi[2:0]` is set. This is the zero-shift case.
- R10: The outputs follow the inputs of the previous clock when `in_valid` was high. A cycle with `in_valid` low gives low flags on the next cycle and leaves `result` unchanged.
- R11: Synchronous active-high `rst` clears `out_valid`, all flags and `result` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operands are taken on this edge |
| src | input | 128 | Source vector |
| imm_hi | input | 4 | High immediate field: lane size and upper shift bits |
| imm_lo | input | 3 | Low immediate field: lower shift bits |
| hi_half | input | 1 | Selects the upper 64 bits of `src` as lane source |
| out_valid | output | 1 | Result is valid |
| result | output | 128 | Widened, shifted lanes |
| out_undef | output | 1 | Undefined encoding was presented |
| out_redirect | output | 1 | Encoding belongs to another operation class |
| out_pure_ext | output | 1 | Zero-shift case (plain sign extension) |

## Verification
The assertions check the following on every cycle:
- the one-cycle path from an accepted encoding to the undefined and redirect flags;
- mutual exclusion of the three outcome flags;
- a zero result under an error;
- the zero-shift flag implying a valid output;
- idle cycles holding the result;
- sign extension of lane 0 from the selected half in the byte zero-shift case.

Only the bench scenarios can show the full arithmetic across all lanes:
- truncation of negative values shifted to the top bit;
- placement of every lane in the 16- and 32-bit sizes;
- the largest legal shifts.

Randomised legal encodings are compared against an independent model.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
  localparam int IMM_HI_W = 4;
  localparam int IMM_LO_W = 3;
  localparam int IMM_W    = IMM_HI_W + IMM_LO_W;
  localparam int SHAMT_W  = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } lane_sz_e;

  typedef struct packed {
    lane_sz_e           sz;
    logic [SHAMT_W-1:0] shamt;
    logic               undef;
    logic               redirect;
    logic               pure_ext;
  } dec_t;
endpackage

// File: rtl/wsl_decode.sv
module wsl_decode
  import wsl_pkg::*;
#(
  parameter int BASE_W = 8
) (
  input  logic [IMM_HI_W-1:0] imm_hi,
  input  logic [IMM_LO_W-1:0] imm_lo,
  output dec_t                dec
);
  logic [IMM_W-1:0] imm_full;
  logic [IMM_W-1:0] lane_bits;
  logic [IMM_W-1:0] diff;

  always_comb begin
    dec          = '0;
    dec.redirect = (imm_hi == '0);
    dec.undef    = imm_hi[IMM_HI_W-1];
    if (imm_hi[2])      dec.sz = SZ_WORD;
    else if (imm_hi[1]) dec.sz = SZ_HALF;
    else                dec.sz = SZ_BYTE;
    imm_full  = {imm_hi, imm_lo};
    lane_bits = IMM_W'(BASE_W) << dec.sz;
    diff      = imm_full - lane_bits;
    dec.shamt = SHAMT_W'(diff);
    dec.pure_ext = !dec.undef && !dec.redirect && (imm_lo == '0)
                   && ($countones(imm_hi) == 1);
  end
endmodule

// File: rtl/wsl_widen.sv
module wsl_widen
  import wsl_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [HALF_W-1:0]   half,
  input  logic [SHAMT_W-1:0]  shamt,
  output logic [2*HALF_W-1:0] wide
);
  localparam int LANES  = HALF_W / LANE_W;
  localparam int WIDE_W = 2 * LANE_W;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    logic [LANE_W-1:0] lane;
    logic [WIDE_W-1:0] ext;
    assign lane = half[e*LANE_W +: LANE_W];
    assign ext  = {{LANE_W{lane[LANE_W-1]}}, lane};
    assign wide[e*WIDE_W +: WIDE_W] = ext << shamt;
  end
endmodule

// File: rtl/wsl_unit.sv
module wsl_unit
  import wsl_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int BASE_W = 8,
  parameter int NUM_SZ = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [2*HALF_W-1:0]  src,
  input  logic [IMM_HI_W-1:0]  imm_hi,
  input  logic [IMM_LO_W-1:0]  imm_lo,
  input  logic                 hi_half,
  output logic                 out_valid,
  output logic [2*HALF_W-1:0]  result,
  output logic                 out_undef,
  output logic                 out_redirect,
  output logic                 out_pure_ext
);
  localparam int FULL_W = 2 * HALF_W;

  dec_t              dec;
  logic              legal;
  logic [HALF_W-1:0] half;
  logic [FULL_W-1:0] wide [NUM_SZ];
  logic [FULL_W-1:0] wide_sel;

  wsl_decode #(.BASE_W(BASE_W)) u_dec (
    .imm_hi(imm_hi),
    .imm_lo(imm_lo),
    .dec   (dec)
  );

  assign legal = !dec.undef && !dec.redirect;
  assign half  = hi_half ? src[FULL_W-1:HALF_W] : src[HALF_W-1:0];

  for (genvar k = 0; k < NUM_SZ; k++) begin : g_size
    wsl_widen #(.HALF_W(HALF_W), .LANE_W(BASE_W << k)) u_widen (
      .half (half),
      .shamt(dec.shamt),
      .wide (wide[k])
    );
  end

  always_comb begin
    wide_sel = '0;
    for (int k = 0; k < NUM_SZ; k++)
      if (int'(dec.sz) == k) wide_sel = wide[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_undef    <= 1'b0;
      out_redirect <= 1'b0;
      out_pure_ext <= 1'b0;
      result       <= '0;
    end else begin
      out_valid    <= in_valid && legal;
      out_undef    <= in_valid && dec.undef;
      out_redirect <= in_valid && dec.redirect;
      out_pure_ext <= in_valid && dec.pure_ext;
      if (in_valid) result <= legal ? wide_sel : '0;
    end
  end
endmodule

// File: rtl/wsl_unit_chk.sv
module wsl_unit_chk #(
  parameter int HALF_W = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [2*HALF_W-1:0] src,
  input logic [3:0]          imm_hi,
  input logic [2:0]          imm_lo,
  input logic                hi_half,
  input logic                out_valid,
  input logic [2*HALF_W-1:0] result,
  input logic                out_undef,
  input logic                out_redirect,
  input logic                out_pure_ext
);
  logic [7:0] first_byte;
  assign first_byte = hi_half ? src[HALF_W +: 8] : src[7:0];

  // R6
  undef_flag_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && imm_hi[3] |=> out_undef);

  // R7
  redirect_flag_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && imm_hi == 4'b0000 |=> out_redirect && !out_undef);

  // R8
  outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_valid, out_undef, out_redirect}));

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_undef || out_redirect) |-> result == '0);

  // R9
  pure_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_pure_ext |-> out_valid);

  // R10
  idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !out_undef && !out_redirect && !out_pure_ext);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  // R1
  lane0_ext_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && imm_hi == 4'b0001 && imm_lo == 3'b000 |=>
      result[15:0] == {{8{$past(first_byte[7])}}, $past(first_byte)});

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid && !out_undef && !out_redirect && result == '0);
endmodule

bind wsl_unit wsl_unit_chk #(.HALF_W(HALF_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .src(src),
  .imm_hi(imm_hi), .imm_lo(imm_lo), .hi_half(hi_half),
  .out_valid(out_valid), .result(result), .out_undef(out_undef),
  .out_redirect(out_redirect), .out_pure_ext(out_pure_ext)
);

// File: tb/wsl_unit_test.sv
module wsl_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] src = '0;
  logic [3:0]   imm_hi = '0;
  logic [2:0]   imm_lo = '0;
  logic         hi_half = 1'b0;
  logic         out_valid, out_undef, out_redirect, out_pure_ext;
  logic [127:0] result;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  wsl_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src),
    .imm_hi(imm_hi), .imm_lo(imm_lo), .hi_half(hi_half),
    .out_valid(out_valid), .result(result), .out_undef(out_undef),
    .out_redirect(out_redirect), .out_pure_ext(out_pure_ext)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [127:0] s, input logic [3:0] h,
                                         input logic [2:0] l, input logic up);
    logic [63:0]  hv;
    logic [127:0] r;
    int w, sh;
    hv = up ? s[127:64] : s[63:0];
    w  = h[2] ? 32 : (h[1] ? 16 : 8);
    sh = int'({h, l}) - w;
    r  = '0;
    for (int e = 0; e < 64 / w; e++) begin
      longint v;
      v = longint'(hv >> (e * w));
      v = (v <<< (64 - w)) >>> (64 - w);
      v = v <<< sh;
      for (int b = 0; b < 2 * w; b++) r[2 * w * e + b] = v[b];
    end
    return r;
  endfunction

  task automatic apply(input logic [127:0] s, input logic [3:0] h,
                       input logic [2:0] l, input logic up);
    @(negedge clk);
    src = s; imm_hi = h; imm_lo = l; hi_half = up; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 reset valid", 128'(out_valid), 128'd0);
    chk("R11 reset flags", 128'({out_undef, out_redirect, out_pure_ext}), 128'd0);
    chk("R11 reset result", result, 128'd0);
  endtask

  task automatic t_bytes_low;
    apply({64'hFFFF_FFFF_FFFF_FFFF, 64'h0706_0504_0302_0100}, 4'b0001, 3'b000, 1'b0);
    chk("R5 byte placement", result, 128'h0007_0006_0005_0004_0003_0002_0001_0000);
    chk("R9 byte pure ext", 128'({out_valid, out_pure_ext}), 128'd3);
  endtask

  task automatic t_bytes_high;
    apply({64'h8877_6655_4433_2211, 64'h0}, 4'b0001, 3'b000, 1'b1);
    chk("R1 upper half", result, 128'hFF88_0077_0066_0055_0044_0033_0022_0011);
  endtask

  task automatic t_byte_trunc;
    apply({64'h0, 64'h7F80_7F80_7F80_7F80}, 4'b0001, 3'b111, 1'b0);
    chk("R4 byte shift 7 truncation", result, 128'h3F80C000_3F80C000_3F80C000_3F80C000);
    chk("R9 shifted not pure", 128'({out_valid, out_pure_ext}), 128'd2);
  endtask

  task automatic t_half_max;
    apply({64'h0, 64'hFFFF_0001_8000_0003}, 4'b0011, 3'b111, 1'b0);
    chk("R3 half shift 15", result, 128'hFFFF8000_00008000_C0000000_00018000);
    apply({64'h0, 64'h0102_0304_0506_0708}, 4'b0011, 3'b000, 1'b0);
    chk("R2 half shift 8", result, model({64'h0, 64'h0102_0304_0506_0708}, 4'b0011, 3'b000, 1'b0));
    chk("R9 two bits set not pure", 128'(out_pure_ext), 128'd0);
  endtask

  task automatic t_word;
    apply({64'h8000_0000_1234_5678, 64'h0}, 4'b0100, 3'b000, 1'b1);
    chk("R2 word ext", result, {64'hFFFF_FFFF_8000_0000, 64'h0000_0000_1234_5678});
    chk("R9 word pure", 128'(out_pure_ext), 128'd1);
    apply({64'h0, 64'h0000_0003_FFFF_FFFF}, 4'b0111, 3'b111, 1'b0);
    chk("R3 word shift 31", result, {64'h0000_0001_8000_0000, 64'hFFFF_FFFF_8000_0000});
  endtask

  task automatic t_undef;
    apply({128{1'b1}}, 4'b1010, 3'b101, 1'b0);
    chk("R6 undef flag", 128'({out_undef, out_redirect}), 128'd2);
    chk("R8 undef result zero", result, 128'd0);
    chk("R8 undef not valid", 128'(out_valid), 128'd0);
  endtask

  task automatic t_redirect;
    apply({128{1'b1}}, 4'b0000, 3'b011, 1'b1);
    chk("R7 redirect flag", 128'({out_undef, out_redirect}), 128'd1);
    chk("R8 redirect result zero", result, 128'd0);
    chk("R8 redirect not valid", 128'(out_valid), 128'd0);
  endtask

  task automatic t_idle;
    logic [127:0] held;
    apply({64'h0, 64'h1111_2222_3333_4444}, 4'b0010, 3'b010, 1'b0);
    held = result;
    @(negedge clk);
    src = '1; imm_hi = 4'b1000;
    @(negedge clk);
    chk("R10 idle no flags", 128'({out_valid, out_undef, out_redirect, out_pure_ext}), 128'd0);
    chk("R10 idle result held", result, held);
  endtask

  task automatic t_random;
    for (int i = 0; i < 40; i++) begin
      logic [127:0] s;
      logic [3:0] h;
      logic [2:0] l;
      logic up;
      s  = {$urandom, $urandom, $urandom, $urandom};
      h  = 4'($urandom_range(1, 7));
      l  = 3'($urandom_range(0, 7));
      up = 1'($urandom_range(0, 1));
      apply(s, h, l, up);
      chk("R4 random lanes", result, model(s, h, l, up));
      chk("R10 random valid", 128'(out_valid), 128'd1);
    end
  endtask

  task automatic t_midreset;
    apply({64'h0, 64'h0102_0304_0506_0708}, 4'b0001, 3'b001, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 reset clears result", result, 128'd0);
    chk("R11 reset clears valid", 128'(out_valid), 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bytes_low();
    t_bytes_high();
    t_byte_trunc();
    t_half_max();
    t_word();
    t_undef();
    t_redirect();
    t_idle();
    t_random();
    t_midreset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule